// File: doc/BRIEF.md
# Scan-Chain Register Access Bridge

This block lets a debug host reach on-chip registers through a user data register of the test access port. The host shifts a 53-bit command frame into the chain. Each frame holds a read/write flag, a register address, write data and four check bits. When the frame is latched, the command crosses into the system clock domain. There the block issues one single-cycle strobe on a simple register bus. The result of the command comes back in the frame shifted out on the next scan. The block is meant for the second user chain of the device, so the first chain stays free for another debug core. Only one host may own the chain at a time.

Four addresses at the top of the map, starting at `PIO_BASE`, form an indirect window into a larger secondary memory space. Offset 0 holds a pointer. Offset 1 is a data port that reads or writes memory at the pointer and then advances the pointer. Offset 2 holds the step added to the pointer after each data-port access. Every other address goes straight to the register bus. The select, capture, shift and update inputs come from the test access port's state machine, which lies outside this block. The logic is small enough to leave in every build next to the normal register interface.

Top module: `jtag_reg_bridge`

## Requirements
- R1: The command frame is shifted least significant bit first. Frame bit 0 is the write flag (1 = write, 0 = read). Bits 16:1 are the address, bits 48:17 the data, and bits 52:49 the check bits.
- R2: A valid write to an address outside the window produces exactly one `bus_wr` cycle, carrying the frame's address and data.
- R3: A valid read outside the window produces exactly one `bus_rd` cycle. The frame shifted out on the next scan returns `bus_rdata` in bits 48:17 and has bit 0 (done) set.
- R4: Check bit k is the XOR of all frame bits i in 48:0 with i mod 4 = k. On a mismatch the command is dropped and no strobe is issued. The next scan then returns bit 1 (error) = 1 and bit 0 (done) = 0.
- R5: Window offset 0 (pointer) and offset 2 (step) can be written, and a read of either returns the stored value. Both reset to 0.
- R6: A write to window offset 1 gives one `mem_wr` cycle, with `mem_addr` equal to the pointer. The pointer then grows by the step. With a step of 0 the pointer stays put.
- R7: A read of window offset 1 gives one `mem_rd` cycle at the pointer and advances the pointer by the step. The next scan returns `mem_rdata`.
- R8: While `chain_sel` is low, capture, shift and update have no effect.
- R9: After reset all strobes are low, and the first scan shifts out an all-zero frame.
- R10: At most one of the four strobes is high in any cycle, and each lasts a single cycle. `bus_addr` never carries a window address during a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; must be held for a few `tck` edges as well |
| tck | input | 1 | Scan clock |
| chain_sel | input | 1 | This user chain is selected |
| cap_en | input | 1 | Capture the response into the shift register |
| shift_en | input | 1 | Shift one bit from `tdi` |
| upd_en | input | 1 | Latch the shifted frame as a command |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift register bit 0) |
| bus_wr | output | 1 | Register bus write strobe |
| bus_rd | output | 1 | Register bus read strobe |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, valid in the `bus_rd` cycle |
| mem_wr | output | 1 | Secondary memory write strobe |
| mem_rd | output | 1 | Secondary memory read strobe |
| mem_addr | output | 32 | Secondary memory address |
| mem_wdata | output | 32 | Secondary memory write data |
| mem_rdata | input | 32 | Secondary memory read data, valid in the `mem_rd` cycle |

## Verification
The assertions check the strobe rules on every system clock cycle:
- each strobe is one cycle wide and never overlaps another;
- window addresses never appear on the register bus;
- the pointer always stands one step past the address of a memory access;
- no strobe follows a frame that failed its check;
- the done and error flags never both show.

Other behaviour shows only in the bench's scans, since it depends on the serial path, the clock-domain crossing and data returned one scan later. This covers the response frame layout, the data returned by reads, pointer auto-increment over a run of accesses, a zero step, a corrupted frame leaving the register unchanged, and a deselected chain being ignored.

// File: rtl/jrb_pkg.sv
// Shared widths, frame layout and check-bit function for the scan register bridge.
// Assumes a fixed frame: write flag, address, data, check bits (LSB first).
package jrb_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int CHK_W   = 4;
    localparam int PAY_W   = 1 + ADDR_W + DATA_W;
    localparam int FRAME_W = PAY_W + CHK_W;

    typedef struct packed {
        logic [CHK_W-1:0]  chk;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } frame_t;

    // Interleaved parity: check bit k covers payload bits i with i mod CHK_W == k
    function automatic logic [CHK_W-1:0] chk_calc(input logic [PAY_W-1:0] p);
        logic [CHK_W-1:0] c;
        c = '0;
        for (int i = 0; i < PAY_W; i++) begin
            c[i % CHK_W] = c[i % CHK_W] ^ p[i];
        end
        return c;
    endfunction
endpackage

// File: rtl/jrb_scan_reg.sv
// Scan-clock side: shift register, response capture and command hold register.
// Assumes the select/capture/shift/update enables are stable around tck rising edges.
// Each accepted update toggles req_tgl so the system domain can detect it.
module jrb_scan_reg
    import jrb_pkg::*;
(
    input  logic               tck,
    input  logic               rst_n,
    input  logic               chain_sel,
    input  logic               cap_en,
    input  logic               shift_en,
    input  logic               upd_en,
    input  logic               tdi,
    output logic               tdo,
    input  logic [FRAME_W-1:0] resp,
    output logic [FRAME_W-1:0] cmd_hold,
    output logic               req_tgl
);
    logic [FRAME_W-1:0] sr;

    // Capture, shift and latch the frame while this chain is selected
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sr       <= '0;
            cmd_hold <= '0;
            req_tgl  <= 1'b0;
        end else if (chain_sel) begin
            if (cap_en) begin
                sr <= resp;
            end else if (shift_en) begin
                sr <= {tdi, sr[FRAME_W-1:1]};
            end
            if (upd_en) begin
                cmd_hold <= sr;
                req_tgl  <= ~req_tgl;
            end
        end
    end

    assign tdo = sr[0];
endmodule

// File: rtl/jrb_tgl_sync.sv
// Toggle synchroniser: turns each edge of a slow-domain toggle into one clk pulse.
// Assumes toggles are spaced further apart than STAGES+1 clk cycles.
module jrb_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);
    logic [STAGES:0] s;

    // Shift the toggle through the synchroniser chain plus one edge-detect flop
    always_ff @(posedge clk) begin
        if (!rst_n) s <= '0;
        else        s <= {s[STAGES-1:0], tgl_in};
    end

    assign pulse = s[STAGES] ^ s[STAGES-1];
endmodule

// File: rtl/jrb_exec.sv
// System-side command executor: checks the frame, decodes the indirect window,
// drives single-cycle strobes and keeps the response (done, error, read data).
// Assumes cmd is stable whenever pulse is high (held in the scan domain).
module jrb_exec
    import jrb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PIO_BASE = 16'hFFF0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pulse,
    input  frame_t             cmd,
    output logic               bus_wr,
    output logic               bus_rd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               mem_wr,
    output logic               mem_rd,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  pio_addr,
    output logic [DATA_W-1:0]  pio_step,
    output logic               done,
    output logic               err,
    output logic [FRAME_W-1:0] resp
);
    logic       chk_ok;
    logic       in_win;
    logic [1:0] off;
    logic [DATA_W-1:0] rdata;
    frame_t     rsp;

    // Decode validity and window membership of the held command
    always_comb begin
        chk_ok = (chk_calc(cmd[PAY_W-1:0]) == cmd.chk);
        in_win = (cmd.addr[ADDR_W-1:2] == PIO_BASE[ADDR_W-1:2]);
        off    = cmd.addr[1:0];
    end

    // Execute one command per pulse and collect read data one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_wr <= 1'b0; bus_rd <= 1'b0; mem_wr <= 1'b0; mem_rd <= 1'b0;
            bus_addr <= '0; bus_wdata <= '0; mem_addr <= '0; mem_wdata <= '0;
            pio_addr <= '0; pio_step <= '0; rdata <= '0;
            done <= 1'b0; err <= 1'b0;
        end else begin
            bus_wr <= 1'b0;
            bus_rd <= 1'b0;
            mem_wr <= 1'b0;
            mem_rd <= 1'b0;
            if (bus_rd) rdata <= bus_rdata;
            if (mem_rd) rdata <= mem_rdata;
            if (pulse) begin
                if (!chk_ok) begin
                    err  <= 1'b1;
                    done <= 1'b0;
                end else begin
                    err  <= 1'b0;
                    done <= 1'b1;
                    if (!in_win) begin
                        bus_addr  <= cmd.addr;
                        bus_wdata <= cmd.data;
                        bus_wr    <= cmd.wr;
                        bus_rd    <= ~cmd.wr;
                    end else begin
                        case (off)
                            2'd0: if (cmd.wr) pio_addr <= cmd.data; else rdata <= pio_addr;
                            2'd1: begin
                                mem_addr  <= pio_addr;
                                mem_wdata <= cmd.data;
                                mem_wr    <= cmd.wr;
                                mem_rd    <= ~cmd.wr;
                                pio_addr  <= pio_addr + pio_step;
                            end
                            2'd2: if (cmd.wr) pio_step <= cmd.data; else rdata <= pio_step;
                            default: if (!cmd.wr) rdata <= '0;
                        endcase
                    end
                end
            end
        end
    end

    // Response frame: bit0 done, bit1 error, data field carries the last read value
    always_comb begin
        rsp      = '0;
        rsp.wr   = done;
        rsp.addr = {{(ADDR_W-1){1'b0}}, err};
        rsp.data = rdata;
        resp     = rsp;
    end
endmodule

// File: rtl/jtag_reg_bridge.sv
// Top: scan-chain register bridge with a direct register bus and an indirect
// pointer/data/step window into a secondary memory space.
// Assumes the host leaves several clk cycles between update and the next capture.
module jtag_reg_bridge
    import jrb_pkg::*;
#(
    parameter logic [15:0] PIO_BASE    = 16'hFFF0,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tck,
    input  logic        chain_sel,
    input  logic        cap_en,
    input  logic        shift_en,
    input  logic        upd_en,
    input  logic        tdi,
    output logic        tdo,
    output logic        bus_wr,
    output logic        bus_rd,
    output logic [15:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    output logic        mem_wr,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    logic [FRAME_W-1:0] cmd_hold;
    logic [FRAME_W-1:0] resp;
    logic               req_tgl;
    logic               cmd_pulse;
    logic [DATA_W-1:0]  pio_addr;
    logic [DATA_W-1:0]  pio_step;
    logic               done;
    logic               err;

    jrb_scan_reg u_scan (
        .tck(tck), .rst_n(rst_n), .chain_sel(chain_sel), .cap_en(cap_en),
        .shift_en(shift_en), .upd_en(upd_en), .tdi(tdi), .tdo(tdo),
        .resp(resp), .cmd_hold(cmd_hold), .req_tgl(req_tgl)
    );

    jrb_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tgl_in(req_tgl), .pulse(cmd_pulse)
    );

    jrb_exec #(.PIO_BASE(PIO_BASE)) u_exec (
        .clk(clk), .rst_n(rst_n), .pulse(cmd_pulse), .cmd(frame_t'(cmd_hold)),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pio_addr(pio_addr), .pio_step(pio_step),
        .done(done), .err(err), .resp(resp)
    );
endmodule

// File: rtl/jrb_checker.sv
// Cycle-level rules on the system-side strobes, pointer and status flags.
// Attached to every jtag_reg_bridge instance by the bind below.
module jrb_checker #(
    parameter logic [15:0] PIO_BASE = 16'hFFF0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [15:0] bus_addr,
    input logic        mem_wr,
    input logic        mem_rd,
    input logic [31:0] mem_addr,
    input logic [31:0] pio_addr,
    input logic [31:0] pio_step,
    input logic        done,
    input logic        err
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_wr, bus_rd, mem_wr, mem_rd})); // R10
    AST_BUS_WR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_wr); // R2
    AST_BUS_RD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> !bus_rd); // R3
    AST_MEM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |=> !(mem_wr || mem_rd)); // R10
    AST_BUS_NOT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> (bus_addr[15:2] != PIO_BASE[15:2])); // R10
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> (pio_addr == mem_addr + pio_step)); // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !(bus_wr || bus_rd || mem_wr || mem_rd)); // R4
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R4
endmodule

bind jtag_reg_bridge jrb_checker #(.PIO_BASE(PIO_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .pio_addr(pio_addr), .pio_step(pio_step),
    .done(done), .err(err)
);

// File: tb/jtag_reg_bridge_test.sv
module jtag_reg_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tck = 1'b0;
    logic        chain_sel = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic        bus_wr, bus_rd, mem_wr, mem_rd;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata, mem_addr, mem_wdata, mem_rdata;

    int nchk = 0, nerr = 0;
    int n_bwr = 0, n_brd = 0, n_mwr = 0, n_mrd = 0;
    bit finished = 0;
    logic [31:0] dregs [16];
    logic [31:0] mem [64];

    always #5 clk = ~clk;

    jtag_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .tck(tck), .chain_sel(chain_sel),
        .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en), .tdi(tdi), .tdo(tdo),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bench models of the register bus and the secondary memory
    assign bus_rdata = dregs[bus_addr[3:0]];
    assign mem_rdata = mem[mem_addr[5:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) dregs[i] <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= '0;
        end else begin
            if (bus_wr) begin dregs[bus_addr[3:0]] <= bus_wdata; n_bwr <= n_bwr + 1; end
            if (bus_rd) n_brd <= n_brd + 1;
            if (mem_wr) begin mem[mem_addr[5:0]] <= mem_wdata; n_mwr <= n_mwr + 1; end
            if (mem_rd) n_mrd <= n_mrd + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Frame per R1 with check bits per R4
    function automatic logic [52:0] mk(input logic wr, input logic [15:0] a, input logic [31:0] d);
        logic [48:0] p;
        logic [3:0]  c;
        p = {d, a, wr};
        c = '0;
        for (int i = 0; i < 49; i++) c[i % 4] = c[i % 4] ^ p[i];
        return {c, p};
    endfunction

    task automatic tck_pulse;
        #20 tck = 1'b1;
        #20 tck = 1'b0;
    endtask

    task automatic scan(input logic [52:0] fin, input logic sel, output logic [52:0] fout);
        chain_sel = sel;
        cap_en = 1'b1; tck_pulse(); cap_en = 1'b0;
        shift_en = 1'b1;
        for (int i = 0; i < 53; i++) begin
            fout[i] = tdo;
            tdi = fin[i];
            tck_pulse();
        end
        shift_en = 1'b0;
        upd_en = 1'b1; tck_pulse(); upd_en = 1'b0;
        chain_sel = 1'b0;
        repeat (20) @(posedge clk);
        #1;
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VEC [19] = '{
        '{1'b1, 16'h0002, 32'h11111111, 32'h0},
        '{1'b1, 16'h0005, 32'hA5A5A5A5, 32'h0},
        '{1'b0, 16'h0002, 32'h0,        32'h11111111},
        '{1'b0, 16'h0005, 32'h0,        32'hA5A5A5A5},
        '{1'b1, 16'hFFF2, 32'h1,        32'h0},
        '{1'b1, 16'hFFF0, 32'h10,       32'h0},
        '{1'b1, 16'hFFF1, 32'hCAFE0001, 32'h0},
        '{1'b1, 16'hFFF1, 32'hCAFE0002, 32'h0},
        '{1'b0, 16'hFFF0, 32'h0,        32'h12},
        '{1'b1, 16'hFFF0, 32'h10,       32'h0},
        '{1'b0, 16'hFFF1, 32'h0,        32'hCAFE0001},
        '{1'b0, 16'hFFF1, 32'h0,        32'hCAFE0002},
        '{1'b0, 16'hFFF0, 32'h0,        32'h12},
        '{1'b1, 16'hFFF2, 32'h0,        32'h0},
        '{1'b1, 16'hFFF0, 32'h5,        32'h0},
        '{1'b1, 16'hFFF1, 32'h77,       32'h0},
        '{1'b1, 16'hFFF1, 32'h88,       32'h0},
        '{1'b0, 16'hFFF1, 32'h0,        32'h88},
        '{1'b0, 16'hFFF0, 32'h0,        32'h5}
    };

    function automatic string tag_of(input vec_t v);
        if (v.a[15:2] == 14'h3FFC) begin
            if (v.a[1:0] == 2'd1) return v.wr ? "R6" : "R7";
            return "R5";
        end
        return v.wr ? "R2" : "R3";
    endfunction

    // Check the response that follows a command
    task automatic check_resp(input vec_t v, input logic [52:0] r);
        check({tag_of(v), "/R1 done"}, {30'b0, r[1], r[0]}, 32'h1);
        if (!v.wr) check({tag_of(v), " data"}, r[48:17], v.e);
    endtask

    initial begin
        logic [52:0] r;
        logic [52:0] bad;
        int b0;
        repeat (4) tck_pulse();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check("R9 strobes idle", {28'b0, bus_wr, bus_rd, mem_wr, mem_rd}, 32'h0);

        // First scan after reset: all-zero response; command reads the pointer
        scan(mk(1'b0, 16'hFFF0, 32'h0), 1'b1, r);
        check("R9 first frame low", r[31:0], 32'h0);
        check("R9 first frame high", {11'b0, r[52:32]}, 32'h0);

        // Vector table walk: each scan returns the previous command's result
        scan(mk(VEC[0].wr, VEC[0].a, VEC[0].d), 1'b1, r);
        check("R5 pointer reset", r[48:17], 32'h0);
        for (int i = 1; i < 19; i++) begin
            scan(mk(VEC[i].wr, VEC[i].a, VEC[i].d), 1'b1, r);
            check_resp(VEC[i-1], r);
        end
        scan(mk(1'b0, 16'h0002, 32'h0), 1'b1, r);
        check_resp(VEC[18], r);

        check("R10 bus_wr count", n_bwr, 2);
        check("R10 bus_rd count", n_brd, 3);
        check("R10 mem_wr count", n_mwr, 4);
        check("R10 mem_rd count", n_mrd, 3);
        check("R6 mem[16]", mem[16], 32'hCAFE0001);
        check("R6 mem[17]", mem[17], 32'hCAFE0002);
        check("R6 zero step", mem[5], 32'h88);

        // Corrupted frame: one data bit flipped after the check bits were computed
        b0 = n_bwr;
        bad = mk(1'b1, 16'h0002, 32'h99999999);
        bad[20] = ~bad[20];
        scan(bad, 1'b1, r);
        scan(mk(1'b0, 16'h0002, 32'h0), 1'b1, r);
        check("R4 error flags", {30'b0, r[1], r[0]}, 32'h2);
        check("R4 no strobe", n_bwr, b0);

        // Deselected chain: a write scanned with chain_sel low must be ignored
        scan(mk(1'b1, 16'h0005, 32'h0), 1'b0, r);
        scan(mk(1'b0, 16'h0005, 32'h0), 1'b1, r);
        check("R4 register unchanged", r[48:17], 32'h11111111);
        check("R4 error cleared", {30'b0, r[1], r[0]}, 32'h1);
        scan(mk(1'b0, 16'h0002, 32'h0), 1'b1, r);
        check("R8 ignored write", r[48:17], 32'hA5A5A5A5);
        check("R8 no strobe", n_bwr, b0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule